// File: doc/BRIEF.md
# Capture/compare timer status logic

A 16-bit free-running counter, advanced by a prescaler, serves two capture inputs and two compare channels. A rising edge on a capture pin copies the counter into that channel's capture register. A compare channel fires when the counter steps onto its programmed value. The counter wrapping past its maximum raises an overflow event. Each of these five events sets its own sticky flag in one status byte. The OR of the flags drives an interrupt request.

Software clears a flag in two steps. First it reads the status byte while the flag is set, which arms that flag. Then it reads or writes the low byte of the register that belongs to the flag. A flag that becomes set after the status read stays set through the following low-byte access. The alternate counter view gives software a way to sample the counter without disturbing the overflow flag. A software disable bit freezes the prescaler and the counter and forces both compare pins low. Every register stays reachable while the timer is disabled.

Top module: `cc_timer_status`

## Requirements
- R1: Compare channel 1 sets status bit 6 in the cycle the counter steps onto the 16-bit value in compare-1 (high byte at address 4h, low byte at address 5h, reset value FFFFh).
- R2: Compare channel 2 sets status bit 3 in the cycle the counter steps onto the value in compare-2 (high byte at 6h, low byte at 7h, reset value FFFFh).
- R3: Status bit 5 sets when the counter steps from FFFFh to 0000h. The counter high byte reads at 0h and the low byte at 1h.
- R4: A rising edge on capture pin 1 (icap_i[0]) sets status bit 7 and latches the counter into capture-1 (high at 8h, low at 9h). Capture pin 2 (icap_i[1]) sets bit 4 and latches into capture-2 (high at Ah, low at Bh). Capture works while the timer is disabled.
- R5: A flag clears only after two steps: a read of the status byte (address Ch) while the flag was set, then a read or write of the flag's own low byte: 5h for bit 6, 1h for bit 5, Bh for bit 4, 7h for bit 3, 9h for bit 7. A low-byte access with no arming status read leaves the flag set.
- R6: Reading or writing the alternate counter low byte (3h) never clears bit 5. The alternate high byte is at 2h.
- R7: A flag that sets after the status read is not cleared by the next access to its low byte.
- R8: Status bit 2 is a read/write disable bit, 0 after reset. While it is 1, the prescaler and counter hold their value and ocmp_o reads 00. Status bits 1:0 always read 0, and writes leave status bits 7:3 unchanged.
- R9: A write to the counter low byte (1h or 3h) loads the counter with FFFCh and restarts the prescaler, whether or not the timer is disabled. With the default prescaler the counter then advances once every 4 clocks.
- R10: Reading a counter high byte (0h or 2h) latches the current low byte. The next counter low-byte read (1h or 3h) returns that latched value even if the counter has moved on.
- R11: irq_o is 1 exactly when at least one of status bits 7:3 is set.
- R12: After reset the status byte reads 00h, irq_o is 0 and ocmp_o is 00.
- R13: Each compare output (ocmp_o[0] for channel 1, ocmp_o[1] for channel 2) toggles on every match of its channel and is driven while the timer is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| rd_i | input | 1 | Read strobe, side effects at the clock edge |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| icap_i | input | 2 | Capture pins, asynchronous |
| ocmp_o | output | 2 | Compare output pins |
| irq_o | output | 1 | Interrupt request |

## Verification
If an arm bit is wrong, the fault shows on the next low-byte access. A flag stays set when it should clear, which shows at irq_o and in the next status read, or a flag clears without the status read or after a late set. A counter or prescaler that runs while disabled, or that loads the wrong value, shows in the next counter or capture read as a wrong byte. A broken low-byte latch shows in the low read that follows a high read, tens of cycles later, as the live byte in place of the latched one.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int CNT_W = 16;
  localparam int NFLAG = 5;

  localparam logic [3:0] A_CNT_H  = 4'h0;
  localparam logic [3:0] A_CNT_L  = 4'h1;
  localparam logic [3:0] A_ACNT_H = 4'h2;
  localparam logic [3:0] A_ACNT_L = 4'h3;
  localparam logic [3:0] A_CMP1_H = 4'h4;
  localparam logic [3:0] A_CMP1_L = 4'h5;
  localparam logic [3:0] A_CMP2_H = 4'h6;
  localparam logic [3:0] A_CMP2_L = 4'h7;
  localparam logic [3:0] A_CAP1_H = 4'h8;
  localparam logic [3:0] A_CAP1_L = 4'h9;
  localparam logic [3:0] A_CAP2_H = 4'hA;
  localparam logic [3:0] A_CAP2_L = 4'hB;
  localparam logic [3:0] A_STAT   = 4'hC;

  // flag vector index; status byte = {flags, dis, 2'b00}
  localparam int F_CMP2 = 0;
  localparam int F_CAP2 = 1;
  localparam int F_OVF  = 2;
  localparam int F_CMP1 = 3;
  localparam int F_CAP1 = 4;
endpackage

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int W = 16,
  parameter int DIV = 4,
  parameter logic [W-1:0] LOAD_VAL = 16'hFFFC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         tick_o,
  output logic         wrap_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PMAX = PW'(DIV - 1);

  logic [PW-1:0] pre_q;
  logic [W-1:0]  cnt_q;

  assign tick_o    = en_i && (pre_q == PMAX);
  assign cnt_nxt_o = cnt_q + 1'b1;
  assign wrap_o    = tick_o && (&cnt_q);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= LOAD_VAL;
    end else if (load_i) begin
      pre_q <= '0;
      cnt_q <= LOAD_VAL;
    end else if (en_i) begin
      pre_q <= tick_o ? '0 : pre_q + 1'b1;
      if (tick_o) cnt_q <= cnt_nxt_o;
    end
  end

  p_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(en_i) && !$past(load_i)) |-> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/cct_capture.sv
module cct_capture #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pin_i,
  input  logic [W-1:0] cnt_i,
  output logic         evt_o,
  output logic [W-1:0] cap_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], pin_i};
  end

  assign evt_o = sync_q[1] && !sync_q[2];

  // capture value is undefined at reset
  always_ff @(posedge clk_i) begin
    if (evt_o) cap_o <= cnt_i;
  end
endmodule

// File: rtl/cct_flags.sv
module cct_flags #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         arm_i,
  input  logic [N-1:0] acc_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q, armed_q, clr;

  assign clr     = armed_q & acc_i;
  assign flags_o = flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      armed_q <= '0;
    end else begin
      flags_q <= set_i | (flags_q & ~clr);
      if (arm_i) armed_q <= flags_q;
      else       armed_q <= armed_q & ~clr;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_chk
    p_two_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flags_q[k]) |-> ($past(armed_q[k]) && $past(acc_i[k])));
  end
endmodule

// File: rtl/cc_timer_status.sv
module cc_timer_status
  import cct_pkg::*;
#(
  parameter int PRESC_DIV = 4,
  parameter logic [CNT_W-1:0] LOAD_VAL = 16'hFFFC
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] addr_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic [1:0] icap_i,
  output logic [1:0] ocmp_o,
  output logic       irq_o
);
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             tick, wrap, load, dis_q;
  logic [CNT_W-1:0] cmp_q [2];
  logic [CNT_W-1:0] cap   [2];
  logic [1:0]       cap_evt, match, tog_q;
  logic [NFLAG-1:0] flags, fset, facc;
  logic [7:0]       lo_buf_q;
  logic             lo_vld_q;

  wire acc = rd_i | wr_i;
  assign load = wr_i && (addr_i == A_CNT_L || addr_i == A_ACNT_L);

  cct_counter #(.W(CNT_W), .DIV(PRESC_DIV), .LOAD_VAL(LOAD_VAL)) u_cnt (
    .clk_i, .rst_ni, .en_i(!dis_q), .load_i(load),
    .cnt_o(cnt), .cnt_nxt_o(cnt_nxt), .tick_o(tick), .wrap_o(wrap)
  );

  for (genvar k = 0; k < 2; k++) begin : g_ch
    cct_capture #(.W(CNT_W)) u_cap (
      .clk_i, .rst_ni, .pin_i(icap_i[k]), .cnt_i(cnt),
      .evt_o(cap_evt[k]), .cap_o(cap[k])
    );
    assign match[k] = tick && !load && (cnt_nxt == cmp_q[k]);
  end

  assign fset[F_CMP1] = match[0];
  assign fset[F_CMP2] = match[1];
  assign fset[F_OVF]  = wrap && !load;
  assign fset[F_CAP1] = cap_evt[0];
  assign fset[F_CAP2] = cap_evt[1];

  assign facc[F_CMP1] = acc && addr_i == A_CMP1_L;
  assign facc[F_CMP2] = acc && addr_i == A_CMP2_L;
  assign facc[F_OVF]  = acc && addr_i == A_CNT_L;
  assign facc[F_CAP1] = acc && addr_i == A_CAP1_L;
  assign facc[F_CAP2] = acc && addr_i == A_CAP2_L;

  cct_flags #(.N(NFLAG)) u_flags (
    .clk_i, .rst_ni, .set_i(fset), .arm_i(rd_i && addr_i == A_STAT),
    .acc_i(facc), .flags_o(flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q    <= 1'b0;
      cmp_q[0] <= '1;
      cmp_q[1] <= '1;
      tog_q    <= '0;
      lo_buf_q <= '0;
      lo_vld_q <= 1'b0;
    end else begin
      tog_q <= tog_q ^ match;
      if (wr_i) begin
        case (addr_i)
          A_STAT:   dis_q          <= wdata_i[2];
          A_CMP1_H: cmp_q[0][15:8] <= wdata_i;
          A_CMP1_L: cmp_q[0][7:0]  <= wdata_i;
          A_CMP2_H: cmp_q[1][15:8] <= wdata_i;
          A_CMP2_L: cmp_q[1][7:0]  <= wdata_i;
          default: ;
        endcase
      end
      if (rd_i && (addr_i == A_CNT_H || addr_i == A_ACNT_H)) begin
        lo_buf_q <= cnt[7:0];
        lo_vld_q <= 1'b1;
      end else if (rd_i && (addr_i == A_CNT_L || addr_i == A_ACNT_L)) begin
        lo_vld_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_CNT_H, A_ACNT_H: rdata_o = cnt[15:8];
      A_CNT_L, A_ACNT_L: rdata_o = lo_vld_q ? lo_buf_q : cnt[7:0];
      A_CMP1_H:          rdata_o = cmp_q[0][15:8];
      A_CMP1_L:          rdata_o = cmp_q[0][7:0];
      A_CMP2_H:          rdata_o = cmp_q[1][15:8];
      A_CMP2_L:          rdata_o = cmp_q[1][7:0];
      A_CAP1_H:          rdata_o = cap[0][15:8];
      A_CAP1_L:          rdata_o = cap[0][7:0];
      A_CAP2_H:          rdata_o = cap[1][15:8];
      A_CAP2_L:          rdata_o = cap[1][7:0];
      A_STAT:            rdata_o = {flags, dis_q, 2'b00};
      default:           rdata_o = 8'h00;
    endcase
  end

  assign ocmp_o = dis_q ? 2'b00 : tog_q;
  assign irq_o  = |flags;

  p_ovf_at_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[F_OVF]) |-> ($past(cnt) == 16'hFFFF));
  p_cmp1_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[F_CMP1]) |-> (cnt == $past(cmp_q[0])));
  p_cmp2_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[F_CMP2]) |-> (cnt == $past(cmp_q[1])));
  p_pins_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dis_q) |-> $stable(tog_q));
endmodule

// File: tb/cc_timer_status_test.sv
`timescale 1ns/1ps
module cc_timer_status_test;
  typedef struct {
    logic [7:0] exp;
    logic [7:0] mask;
    string      tag;
  } item_t;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] addr = '0;
  logic       rd = 0, wr = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] icap = '0;
  logic [1:0] ocmp;
  logic       irq;

  int checks = 0, errors = 0;
  bit done = 0;
  item_t q[$];
  item_t it;

  always #2.5 clk = ~clk;

  cc_timer_status uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .icap_i(icap), .ocmp_o(ocmp), .irq_o(irq)
  );

  // monitor: compares each read against the scoreboard queue
  always @(negedge clk) begin
    if (rd && !done) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: act %02h exp none", rdata);
      end else begin
        it = q.pop_front();
        if ((rdata & it.mask) != (it.exp & it.mask)) begin
          errors++;
          $display("FAIL %s: act %02h exp %02h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [7:0] e,
                        input logic [7:0] m, input string tag);
    q.push_back('{exp: e, mask: m, tag: tag});
    addr = a; rd = 1;
    @(posedge clk); #1 rd = 0;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1;
    @(posedge clk); #1 wr = 0;
  endtask

  task automatic pin_chk(input bit is_irq, input logic [1:0] e, input string tag);
    logic [1:0] act;
    @(negedge clk);
    act = is_irq ? {1'b0, irq} : ocmp;
    checks++;
    if (act != e) begin
      errors++;
      $display("FAIL %s: act %0b exp %0b", tag, act, e);
    end
    @(posedge clk); #1;
  endtask

  task automatic pulse(input int k);
    icap[k] = 1'b1; idle(5);
    icap[k] = 1'b0; idle(10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R12 reset state
    rd_exp(4'hC, 8'h00, 8'hFF, "R12 status after reset");
    pin_chk(1, 2'b00, "R12 irq after reset");
    pin_chk(0, 2'b00, "R12 ocmp after reset");

    // R8 reserved bits and flag bits not writable
    wr_reg(4'hC, 8'h07);
    rd_exp(4'hC, 8'h04, 8'hFF, "R8 reserved read zero");
    wr_reg(4'hC, 8'hFC);
    rd_exp(4'hC, 8'h04, 8'hFF, "R8 flags not writable");

    // setup compares, load counter while disabled
    wr_reg(4'h4, 8'h00); wr_reg(4'h5, 8'h10);
    wr_reg(4'h6, 8'h00); wr_reg(4'h7, 8'h20);
    wr_reg(4'h1, 8'h00);
    rd_exp(4'h0, 8'hFF, 8'hFF, "R9 load high");
    rd_exp(4'h1, 8'hFC, 8'hFF, "R9 load low");
    idle(20);
    rd_exp(4'h0, 8'hFF, 8'hFF, "R8 frozen high");
    rd_exp(4'h1, 8'hFC, 8'hFF, "R8 frozen low");

    // run through wrap and both compares
    wr_reg(4'hC, 8'h00);
    idle(200);
    wr_reg(4'hC, 8'h04);
    wr_reg(4'h5, 8'h10); // access without arming
    rd_exp(4'hC, 8'h6C, 8'hFF, "R1 R2 R3 R5 flags set, unarmed access kept");
    pin_chk(1, 2'b01, "R11 irq with flags");
    pin_chk(0, 2'b00, "R8 ocmp forced low");
    rd_exp(4'h0, 8'h00, 8'hFF, "R3 counter wrapped");

    // two-step clears
    rd_exp(4'h3, 8'h00, 8'h00, "R6 alias low read");
    rd_exp(4'hC, 8'h6C, 8'hFF, "R6 alias keeps overflow");
    rd_exp(4'h1, 8'h00, 8'h00, "R5 counter low read");
    rd_exp(4'hC, 8'h4C, 8'hFF, "R5 overflow cleared");
    rd_exp(4'h5, 8'h10, 8'hFF, "R1 compare-1 low");
    rd_exp(4'hC, 8'h0C, 8'hFF, "R5 compare-1 cleared");
    wr_reg(4'h7, 8'h20);
    rd_exp(4'hC, 8'h04, 8'hFF, "R5 compare-2 cleared by write");
    pin_chk(1, 2'b00, "R11 irq low when clear");

    // R13 compare pins toggled once each
    wr_reg(4'hC, 8'h00);
    pin_chk(0, 2'b11, "R13 ocmp toggled");
    wr_reg(4'hC, 8'h04);
    pin_chk(0, 2'b00, "R8 ocmp forced low again");

    // captures at frozen FFFCh
    wr_reg(4'h1, 8'h00);
    pulse(1);
    rd_exp(4'hC, 8'h14, 8'hFF, "R4 capture-2 flag");
    pulse(0);
    rd_exp(4'h9, 8'hFC, 8'hFF, "R4 capture-1 low");
    rd_exp(4'hB, 8'hFC, 8'hFF, "R4 capture-2 low");
    rd_exp(4'hA, 8'hFF, 8'hFF, "R4 capture-2 high");
    rd_exp(4'hC, 8'h84, 8'hFF, "R7 late flag survives access");
    rd_exp(4'h8, 8'hFF, 8'hFF, "R4 capture-1 high");
    rd_exp(4'h9, 8'hFC, 8'hFF, "R5 capture-1 low clear");
    rd_exp(4'hC, 8'h04, 8'hFF, "R5 capture flags cleared");

    // R10 coherent read while running
    wr_reg(4'hC, 8'h00);
    wr_reg(4'h1, 8'h00);
    rd_exp(4'h0, 8'hFF, 8'hFF, "R10 high read");
    idle(40);
    rd_exp(4'h1, 8'hFC, 8'hFF, "R10 latched low");
    wr_reg(4'hC, 8'h04);
    rd_exp(4'hC, 8'h24, 8'hFF, "R3 overflow after reload run");
    pin_chk(1, 2'b01, "R11 irq from overflow");

    idle(2);
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard leftover: act %0d exp 0", q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule